// File: doc/BRIEF.md
# Segmented Data Memory Addressing Unit

This unit is the data-memory side of a small 8-bit controller. It holds the accumulator and four memory-mapped registers: two pointers (X and B), a stack pointer (SP) and a segment register (S). Every data access forms a 16-bit address. The segment register supplies the upper byte. The lower byte comes either from the operand or from one of the two pointers.

A decoded operation arrives each cycle. The operation can be idle, load, exchange or load-immediate. It comes with an addressing mode and a post-update choice. The unit finishes the operation at the next rising clock edge.

- The top sixteen offsets of every segment alias the same storage: twelve shared general registers and the four mapped registers.
- Segment 0 holds RAM below its reserved window. That window always reads as all ones.
- Segments 1 to 3 each hold a private RAM bank.
- Every other location reads as a fixed filler value and ignores writes.
- The indirect modes can step their pointer after the access.

Top module: `dmem_seg_unit`

## Requirements
- R1: After reset, the accumulator, X, SP, B, S, rdData and every RAM byte (the shared registers, segment 0 RAM and the banked RAM) read 00.
- R2: The access address is S:low. In mode 0 or 3 (direct), low is the operand. In mode 1, low is B. In mode 2, low is X.
- R3: A load (opCode 1) copies the addressed byte into both accOut and rdData at the clock edge that samples it.
- R4: An exchange (opCode 2) writes the old accumulator to the addressed location, and it places the location's old contents in accOut and rdData, all at the same edge.
- R5: In every segment, offsets FC, FD, FE and FF read and write X, SP, B and S. A write to S selects the segment for the next operation.
- R6: Offsets F0 to FB reach twelve shared registers. These registers are the same storage whatever S holds.
- R7: Segment 0 holds RAM at offsets 00 to 6F. Segments 1, 2 and 3 each hold a separate 128-byte RAM at offsets 00 to 7F.
- R8: In segment 0, offsets 70 to 7F read FF and ignore writes.
- R9: Every other location reads 00 and ignores writes. This covers segment 0 offsets 80 to EF, offsets 80 to EF of segments 1 to 3, and offsets 00 to EF of segments 4 to FF.
- R10: The post-update code is 1 for increment and 2 for decrement; 0 and 3 leave the pointer unchanged.
  - In modes 1 and 2, on a load or an exchange, the selected pointer then steps by one, modulo 256.
  - The access itself uses the pointer value from before the step.
  - S is never changed by the step.
  - In direct mode, the post-update code has no effect.
- R11: Suppose an exchange writes the same pointer that it post-updates (offset FC through X, or offset FE through B). The written value is kept and the step is dropped.
- R12: Load-immediate (opCode 3) puts the operand into accOut and rdData. Idle (opCode 0) changes no state and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opCode | input | 2 | 0 idle, 1 load, 2 exchange, 3 load-immediate |
| addrMode | input | 2 | 0/3 direct, 1 B-indirect, 2 X-indirect |
| postUpd | input | 2 | 0/3 none, 1 increment, 2 decrement |
| operand | input | 8 | Direct low address or immediate byte |
| accOut | output | 8 | Accumulator |
| rdData | output | 8 | Byte read by the most recent non-idle operation |

## Verification
The bench builds the unit with its default parameters: four segments, 128-byte banks, 112 bytes of segment 0 RAM, shared registers from F0, and the all-ones window at 70 to 7F. With these values, every region type can be reached by a few exchanges to offset FF. Random traffic keeps S inside 0 to 4, so the private banks, the filler-only segment 4 and the aliased top window are all hit repeatedly. Pointers that drift through FF and 00 push the post-update wrap and the write-versus-step collision into the random stream as well.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_LOAD  = 2'd1,
    OP_XCHG  = 2'd2,
    OP_LDIMM = 2'd3
  } opKind_e;

  typedef enum logic [1:0] {
    AM_DIRECT     = 2'd0,
    AM_IND_B      = 2'd1,
    AM_IND_X      = 2'd2,
    AM_DIRECT_ALT = 2'd3
  } addrMode_e;

  typedef enum logic [1:0] {
    PU_NONE     = 2'd0,
    PU_INC      = 2'd1,
    PU_DEC      = 2'd2,
    PU_NONE_ALT = 2'd3
  } postUpd_e;

  typedef enum logic [2:0] {
    RG_PTR,
    RG_SHARED,
    RG_LOWRAM,
    RG_ONES,
    RG_BANK,
    RG_UNDEF
  } region_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic accLoad;   // accumulator and read register update
    logic accImm;    // take operand instead of memory
    logic memWrite;  // exchange writes old accumulator
    logic useInd;    // low address from a pointer
    logic selX;      // pointer is X (else B)
    logic ptrInc;
    logic ptrDec;
  } ctrlStrobe_t;

endpackage

// File: rtl/dmem_ctrl.sv
module dmem_ctrl
  import dmem_pkg::*;
(
  input  logic [1:0]  opCode,
  input  logic [1:0]  addrMode,
  input  logic [1:0]  postUpd,
  output ctrlStrobe_t strobe
);

  opKind_e   opK;
  addrMode_e modeK;
  postUpd_e  puK;
  logic      memOp;

  assign opK   = opKind_e'(opCode);
  assign modeK = addrMode_e'(addrMode);
  assign puK   = postUpd_e'(postUpd);

  always_comb begin
    memOp           = (opK == OP_LOAD) || (opK == OP_XCHG);
    strobe.accLoad  = (opK != OP_NOP);
    strobe.accImm   = (opK == OP_LDIMM);
    strobe.memWrite = (opK == OP_XCHG);
    strobe.useInd   = memOp && ((modeK == AM_IND_B) || (modeK == AM_IND_X));
    strobe.selX     = (modeK == AM_IND_X);
    strobe.ptrInc   = strobe.useInd && (puK == PU_INC);
    strobe.ptrDec   = strobe.useInd && (puK == PU_DEC);

    // R10: a pointer never steps both ways at once
    p_dir_excl_r10: assert (!(strobe.ptrInc && strobe.ptrDec));
    // R12: load-immediate never writes memory
    p_imm_nowrite_r12: assert (!(strobe.accImm && strobe.memWrite));
  end

endmodule

// File: rtl/dmem_datapath.sv
module dmem_datapath
  import dmem_pkg::*;
#(
  parameter int unsigned SEG_COUNT     = 4,
  parameter int unsigned BANK_BYTES    = 128,
  parameter int unsigned LOW_RAM_BYTES = 112,
  parameter int unsigned SHARED_BASE   = 240,
  parameter int unsigned ONES_LO       = 112,
  parameter int unsigned ONES_HI       = 127,
  parameter logic [7:0]  UNDEF_VALUE   = 8'h00
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic [7:0]  operand,
  output logic [7:0]  accOut,
  output logic [7:0]  rdData
);

  localparam logic [7:0]  PTR_BASE   = 8'hFC;
  localparam int unsigned SHARED_CNT = 252 - SHARED_BASE;
  localparam int unsigned SH_AW      = $clog2(SHARED_CNT);
  localparam int unsigned BANK_AW    = $clog2(BANK_BYTES);
  localparam int unsigned LOW_AW     = $clog2(LOW_RAM_BYTES);
  localparam logic [7:0]  SH_BASE_B  = 8'(SHARED_BASE);
  localparam logic [7:0]  LOW_LIM_B  = 8'(LOW_RAM_BYTES);
  localparam logic [7:0]  BANK_LIM_B = 8'(BANK_BYTES);
  localparam logic [7:0]  ONES_LO_B  = 8'(ONES_LO);
  localparam logic [7:0]  ONES_HI_B  = 8'(ONES_HI);
  localparam logic [7:0]  SEG_LIM_B  = 8'(SEG_COUNT);

  logic [7:0] accReg, rdReg;
  logic [7:0] ptrX, ptrSp, ptrB, segReg;
  logic [7:0] lowAddr;
  region_e    region;
  logic [7:0] readVal;
  logic       ptrWrite;
  logic [7:0] stepVal;
  logic       xBlocked, bBlocked;

  logic [7:0]       sharedMem [SHARED_CNT];
  logic [7:0]       lowMem    [LOW_RAM_BYTES];
  logic [SH_AW-1:0] sharedIdx;
  logic [SEG_COUNT-1:0][7:0] bankRd;

  // Address formation (R2)
  assign lowAddr   = strobe.useInd ? (strobe.selX ? ptrX : ptrB) : operand;
  assign sharedIdx = SH_AW'(lowAddr - SH_BASE_B);

  // Region decode: top window first, then per-segment areas
  always_comb begin
    if (lowAddr >= PTR_BASE)
      region = RG_PTR;
    else if (lowAddr >= SH_BASE_B)
      region = RG_SHARED;
    else if (segReg == 8'd0 && lowAddr < LOW_LIM_B)
      region = RG_LOWRAM;
    else if (segReg == 8'd0 && lowAddr >= ONES_LO_B && lowAddr <= ONES_HI_B)
      region = RG_ONES;
    else if (segReg != 8'd0 && segReg < SEG_LIM_B && lowAddr < BANK_LIM_B)
      region = RG_BANK;
    else
      region = RG_UNDEF;
  end

  // Banked RAM, one per segment 1..SEG_COUNT-1 (R7)
  assign bankRd[0] = UNDEF_VALUE;
  for (genvar g = 1; g < SEG_COUNT; g++) begin : g_bank
    logic [7:0] bankMem [BANK_BYTES];
    logic       bankWe;
    assign bankWe    = strobe.memWrite && region == RG_BANK && segReg == 8'(g);
    assign bankRd[g] = bankMem[lowAddr[BANK_AW-1:0]];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < BANK_BYTES; i++) bankMem[i] <= '0;
      end else if (bankWe) begin
        bankMem[lowAddr[BANK_AW-1:0]] <= accReg;
      end
    end
  end

  // Read multiplexer
  always_comb begin
    unique case (region)
      RG_PTR: begin
        unique case (lowAddr[1:0])
          2'd0:    readVal = ptrX;
          2'd1:    readVal = ptrSp;
          2'd2:    readVal = ptrB;
          default: readVal = segReg;
        endcase
      end
      RG_SHARED: readVal = sharedMem[sharedIdx];
      RG_LOWRAM: readVal = lowMem[lowAddr[LOW_AW-1:0]];
      RG_ONES:   readVal = 8'hFF;
      RG_BANK:   readVal = bankRd[segReg[$clog2(SEG_COUNT)-1:0]];
      default:   readVal = UNDEF_VALUE;
    endcase
  end

  // Shared registers and segment 0 RAM
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SHARED_CNT; i++) sharedMem[i] <= '0;
    end else if (strobe.memWrite && region == RG_SHARED) begin
      sharedMem[sharedIdx] <= accReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LOW_RAM_BYTES; i++) lowMem[i] <= '0;
    end else if (strobe.memWrite && region == RG_LOWRAM) begin
      lowMem[lowAddr[LOW_AW-1:0]] <= accReg;
    end
  end

  // Mapped registers, post-update and accumulator
  assign ptrWrite = strobe.memWrite && region == RG_PTR;
  assign stepVal  = strobe.ptrInc ? 8'h01 : 8'hFF;
  assign xBlocked = ptrWrite && lowAddr[1:0] == 2'd0;
  assign bBlocked = ptrWrite && lowAddr[1:0] == 2'd2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg <= '0;
      rdReg  <= '0;
      ptrX   <= '0;
      ptrSp  <= '0;
      ptrB   <= '0;
      segReg <= '0;
    end else begin
      if (strobe.accLoad) begin
        accReg <= strobe.accImm ? operand : readVal;
        rdReg  <= strobe.accImm ? operand : readVal;
      end
      if (ptrWrite) begin
        unique case (lowAddr[1:0])
          2'd0:    ptrX   <= accReg;
          2'd1:    ptrSp  <= accReg;
          2'd2:    ptrB   <= accReg;
          default: segReg <= accReg;
        endcase
      end
      if (strobe.ptrInc || strobe.ptrDec) begin
        if (strobe.selX) begin
          if (!xBlocked) ptrX <= ptrX + stepVal;
        end else begin
          if (!bBlocked) ptrB <= ptrB + stepVal;
        end
      end
    end
  end

  assign accOut = accReg;
  assign rdData = rdReg;

  // Assertions
  p_load_acc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accLoad && !strobe.accImm) |=> accReg == $past(readVal));

  p_seg_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ptrWrite && lowAddr == 8'hFF) |=> segReg == $past(accReg));

  p_ones_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accLoad && !strobe.accImm && region == RG_ONES) |=> rdReg == 8'hFF);

  p_x_inc_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ptrInc && strobe.selX && !xBlocked) |=> ptrX == $past(ptrX) + 8'd1);

  p_b_dec_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ptrDec && !strobe.selX && !bBlocked) |=> ptrB == $past(ptrB) - 8'd1);

  p_seg_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.ptrInc || strobe.ptrDec) && !(ptrWrite && lowAddr[1:0] == 2'd3))
      |=> $stable(segReg));

  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (xBlocked && strobe.selX && (strobe.ptrInc || strobe.ptrDec))
      |=> ptrX == $past(accReg));

endmodule

// File: rtl/dmem_seg_unit.sv
module dmem_seg_unit
  import dmem_pkg::*;
#(
  parameter int unsigned SEG_COUNT     = 4,
  parameter int unsigned BANK_BYTES    = 128,
  parameter int unsigned LOW_RAM_BYTES = 112,
  parameter int unsigned SHARED_BASE   = 240,
  parameter int unsigned ONES_LO       = 112,
  parameter int unsigned ONES_HI       = 127,
  parameter logic [7:0]  UNDEF_VALUE   = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] opCode,
  input  logic [1:0] addrMode,
  input  logic [1:0] postUpd,
  input  logic [7:0] operand,
  output logic [7:0] accOut,
  output logic [7:0] rdData
);

  ctrlStrobe_t strobe;

  dmem_ctrl u_ctrl (
    .opCode   (opCode),
    .addrMode (addrMode),
    .postUpd  (postUpd),
    .strobe   (strobe)
  );

  dmem_datapath #(
    .SEG_COUNT     (SEG_COUNT),
    .BANK_BYTES    (BANK_BYTES),
    .LOW_RAM_BYTES (LOW_RAM_BYTES),
    .SHARED_BASE   (SHARED_BASE),
    .ONES_LO       (ONES_LO),
    .ONES_HI       (ONES_HI),
    .UNDEF_VALUE   (UNDEF_VALUE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .operand (operand),
    .accOut  (accOut),
    .rdData  (rdData)
  );

endmodule

// File: tb/dmem_seg_unit_bench.sv
`timescale 1ns/1ps
module dmem_seg_unit_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] opCode, addrMode, postUpd;
  logic [7:0] operand;
  logic [7:0] accOut, rdData;

  int testCnt = 0;
  int failCnt = 0;

  always #10 clk = ~clk;

  dmem_seg_unit #(
    .SEG_COUNT(4), .BANK_BYTES(128), .LOW_RAM_BYTES(112),
    .SHARED_BASE(240), .ONES_LO(112), .ONES_HI(127), .UNDEF_VALUE(8'h00)
  ) u_dmem_seg_unit (
    .clk(clk), .rstN(rstN), .opCode(opCode), .addrMode(addrMode),
    .postUpd(postUpd), .operand(operand), .accOut(accOut), .rdData(rdData)
  );

  // Reference state
  logic [7:0] mAcc, mRd, mX, mSp, mB, mS;
  logic [7:0] mShared [12];
  logic [7:0] mRam [4][128];

  function automatic logic [7:0] rdModel(input logic [7:0] seg, input logic [7:0] off);
    if (off >= 8'hFC) begin
      case (off[1:0])
        2'd0: return mX;
        2'd1: return mSp;
        2'd2: return mB;
        default: return mS;
      endcase
    end
    if (off >= 8'hF0) return mShared[off - 8'hF0];
    if (seg == 8'd0) begin
      if (off < 8'h70) return mRam[0][off[6:0]];
      if (off < 8'h80) return 8'hFF;
      return 8'h00;
    end
    if (seg < 8'd4 && off < 8'h80) return mRam[seg[1:0]][off[6:0]];
    return 8'h00;
  endfunction

  task automatic wrModel(input logic [7:0] seg, input logic [7:0] off, input logic [7:0] val);
    if (off >= 8'hFC) begin
      case (off[1:0])
        2'd0: mX = val;
        2'd1: mSp = val;
        2'd2: mB = val;
        default: mS = val;
      endcase
    end else if (off >= 8'hF0) mShared[off - 8'hF0] = val;
    else if (seg == 8'd0 && off < 8'h70) mRam[0][off[6:0]] = val;
    else if (seg != 8'd0 && seg < 8'd4 && off < 8'h80) mRam[seg[1:0]][off[6:0]] = val;
  endtask

  task automatic check(input string tag);
    testCnt++;
    if (accOut !== mAcc || rdData !== mRd) begin
      failCnt++;
      $display("FAIL %s: acc=%02h rd=%02h expected acc=%02h rd=%02h",
               tag, accOut, rdData, mAcc, mRd);
    end
  endtask

  // Drive one operation at a falling edge, check at the next falling edge
  task automatic step(input logic [1:0] op, input logic [1:0] md, input logic [1:0] pu,
                      input logic [7:0] opd, input string tag);
    logic       ind, selX;
    logic [7:0] low, old, d;
    ind  = (op == 2'd1 || op == 2'd2) && (md == 2'd1 || md == 2'd2);
    selX = (md == 2'd2);
    low  = ind ? (selX ? mX : mB) : opd;
    old  = rdModel(mS, low);
    case (op)
      2'd1: begin mAcc = old; mRd = old; end
      2'd2: begin wrModel(mS, low, mAcc); mAcc = old; mRd = old; end
      2'd3: begin mAcc = opd; mRd = opd; end
      default: ;
    endcase
    if (ind && (pu == 2'd1 || pu == 2'd2)) begin
      d = (pu == 2'd1) ? 8'h01 : 8'hFF;
      if (selX) begin
        if (!(op == 2'd2 && low == 8'hFC)) mX = mX + d;
      end else begin
        if (!(op == 2'd2 && low == 8'hFE)) mB = mB + d;
      end
    end
    opCode = op; addrMode = md; postUpd = pu; operand = opd;
    @(negedge clk);
    check(tag);
  endtask

  task automatic setReg(input logic [7:0] off, input logic [7:0] val, input string tag);
    step(2'd3, 2'd0, 2'd0, val, tag);
    step(2'd2, 2'd0, 2'd0, off, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    mAcc = 0; mRd = 0; mX = 0; mSp = 0; mB = 0; mS = 0;
    for (int i = 0; i < 12; i++) mShared[i] = 0;
    for (int s = 0; s < 4; s++) for (int i = 0; i < 128; i++) mRam[s][i] = 0;
    rstN = 1'b0; opCode = 0; addrMode = 0; postUpd = 0; operand = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 reset outputs");
    step(2'd1, 2'd0, 2'd0, 8'hFC, "R1 X after reset");
    step(2'd1, 2'd0, 2'd0, 8'h10, "R1 RAM after reset");

    // load-immediate, exchange, load
    step(2'd3, 2'd0, 2'd0, 8'hA5, "R12 load-immediate");
    step(2'd2, 2'd0, 2'd0, 8'h10, "R4 exchange swap");
    step(2'd1, 2'd0, 2'd0, 8'h10, "R3 load after exchange");
    step(2'd0, 2'd0, 2'd0, 8'h33, "R12 idle holds");

    // all-ones window
    step(2'd1, 2'd0, 2'd0, 8'h75, "R8 ones read");
    setReg(8'h70, 8'h3C, "R8 write ignored");
    step(2'd1, 2'd0, 2'd0, 8'h70, "R8 reread ones");

    // filler region of segment 0
    setReg(8'h85, 8'h11, "R9 write ignored");
    step(2'd1, 2'd0, 2'd0, 8'h85, "R9 filler read");

    // segments and shared registers
    setReg(8'hFF, 8'h02, "R5 write S");
    step(2'd1, 2'd0, 2'd0, 8'hFF, "R5 read S");
    setReg(8'h10, 8'h77, "R7 bank2 write");
    setReg(8'hFF, 8'h01, "R5 switch S");
    step(2'd1, 2'd0, 2'd0, 8'h10, "R7 bank1 separate");
    setReg(8'hF3, 8'h5A, "R6 shared write");
    setReg(8'hFF, 8'h03, "R5 switch S to 3");
    step(2'd1, 2'd0, 2'd0, 8'hF3, "R6 shared alias");

    // post-update wrap and S stability
    setReg(8'hFC, 8'hFF, "R5 write X");
    step(2'd1, 2'd2, 2'd1, 8'h00, "R10 X-indirect pre-step value");
    step(2'd1, 2'd0, 2'd0, 8'hFC, "R10 X wrap to 00");
    setReg(8'hFE, 8'h00, "R5 write B");
    step(2'd1, 2'd1, 2'd2, 8'h00, "R2 B-indirect access");
    step(2'd1, 2'd0, 2'd0, 8'hFE, "R10 B wrap to FF");
    step(2'd1, 2'd0, 2'd0, 8'hFF, "R10 S unchanged");
    step(2'd1, 2'd0, 2'd1, 8'hFE, "R10 direct ignores step");
    step(2'd1, 2'd0, 2'd0, 8'hFE, "R10 B after direct");

    // write beats post-update
    setReg(8'hFC, 8'hFC, "R11 X points at itself");
    step(2'd3, 2'd0, 2'd0, 8'h40, "R11 load value");
    step(2'd2, 2'd2, 2'd1, 8'h00, "R11 exchange through X");
    step(2'd1, 2'd0, 2'd0, 8'hFC, "R11 written value kept");

    // segment without memory
    setReg(8'hFF, 8'h09, "R9 empty segment");
    step(2'd1, 2'd0, 2'd0, 8'h10, "R9 empty segment read");
    step(2'd1, 2'd0, 2'd0, 8'hFF, "R5 alias in any segment");
    step(2'd1, 2'd0, 2'd0, 8'hF3, "R6 shared in empty segment");

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      if (n % 48 == 0) setReg(8'hFF, 8'($urandom_range(0, 4)), "R5 random S");
      step(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
           2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)),
           "R2 R3 R4 R6 R7 R8 R9 R10 R11 random");
    end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule